// File: doc/BRIEF.md
# Stall-Cycle Accumulator with Read Latch

This block is a 12-bit diagnostic counter. It counts the clock cycles in which a processor is held up waiting on its instruction cache. Each cycle in which the stall-request input is high adds one to the count. Performance tuning code reads the count to measure how much time the program loses to misses.

Software reaches the counter through two 8-bit register ports on a simple strobe bus. The high port holds a sticky wrap flag and the top seven counter bits. The low port gives four middle counter bits, and these are frozen at the moment the high port is read. The counter's bit 0 is never visible, so software takes twice the concatenated 11-bit readable value as the stall total. Writing the high port sets the upper counter bits and clears the lower five bits and the wrap flag. Read data is combinational from the current state in the same cycle as the strobe. All state changes at the rising clock edge.

Top module: `stall_accum_top`

## Requirements
- R1: On each rising edge where `stallReq` is 1 and no high-port write occurs, the counter increases by exactly one.
- R2: When `regSelHigh` is 1, `rdData` equals {wrap flag in bit 7, counter bits 11..5 in bits 6..0}, taken from the live counter.
- R3: When `regSelHigh` is 0, `rdData` bits 4..1 show the snapshot field. Bits 7..5 and bit 0 always read 0, so counter bit 0 is never visible.
- R4: A high-port read (`rdStrobe`=1, `regSelHigh`=1) copies counter bits 4..1 into the snapshot field at the clock edge. The copy uses the count before any increment in that same cycle. The field keeps that value until the next high-port read.
- R5: A high-port write (`wrStrobe`=1, `regSelHigh`=1) loads counter bits 11..5 from `wrData` bits 6..0 and clears counter bits 4..0.
- R6: When a high-port write and a stall fall in the same cycle, the write value is loaded and the stall cycle is not counted.
- R7: A counted stall at count 0xFFF makes the count 0x000 and sets the wrap flag. Counting then goes on from zero.
- R8: The wrap flag stays set until a high-port write clears it. `wrData` bit 7 never sets it.
- R9: A write with `regSelHigh`=0 changes neither the counter, the wrap flag nor the snapshot field.
- R10: After reset, both ports read 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| stallReq | input | 1 | High in each cycle the processor is stalled by a miss |
| regSelHigh | input | 1 | 1 selects the high port, 0 the low port |
| rdStrobe | input | 1 | Read access to the selected port this cycle |
| wrStrobe | input | 1 | Write access to the selected port this cycle |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data of the selected port (combinational) |

## Verification
The bench presses on the snapshot timing. It reads the high port in a cycle that also counts a stall. A design that latched the incremented value would show the low field one step off. The bench then reads the low port several times after further stalls. A design that tracked the live count would show the field moving.

The bench also drives a write and a stall in the same cycle, where a design that let the stall win would leave the count one too high. It walks the count through 0xFFF to zero. A design that saturated, or lost the flag on the next count, would be caught there. Writes with bit 7 set and writes to the low port are applied too. A careless decode would set the flag or disturb the count.

// File: rtl/stall_accum_pkg.sv
package stall_accum_pkg;

  // Per-cycle actions the control decoder hands to the datapath
  typedef struct packed {
    logic incr;   // count one stall cycle
    logic load;   // high-port write: load upper field, clear lower bits and flag
    logic snap;   // high-port read: capture middle bits
  } ctrlStrobes_t;

endpackage

// File: rtl/stall_accum_ctrl.sv
module stall_accum_ctrl
  import stall_accum_pkg::*;
(
  input  logic         stallReq,
  input  logic         regSelHigh,
  input  logic         rdStrobe,
  input  logic         wrStrobe,
  output ctrlStrobes_t strobes
);

  logic hiWrite;
  logic hiRead;

  assign hiWrite = wrStrobe & regSelHigh;
  assign hiRead  = rdStrobe & regSelHigh;

  // A write to the high port takes priority over a stall in the same cycle.
  // Low-port writes decode to nothing.
  always_comb begin
    strobes      = '0;
    strobes.load = hiWrite;
    strobes.incr = stallReq & ~hiWrite;
    strobes.snap = hiRead;
  end

endmodule

// File: rtl/stall_accum_dp.sv
module stall_accum_dp
  import stall_accum_pkg::*;
#(
  parameter int CNT_W      = 12,
  parameter int HI_FIELD_W = 7,
  parameter int LO_FIELD_W = 4,
  parameter int DATA_W     = 8
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  ctrlStrobes_t          strobes,
  input  logic                  regSelHigh,
  input  logic [DATA_W-1:0]     wrData,
  output logic [DATA_W-1:0]     rdData,
  output logic [CNT_W-1:0]      accumCnt,
  output logic                  ovfFlag,
  output logic [LO_FIELD_W-1:0] snapField
);

  localparam int HI_LSB = CNT_W - HI_FIELD_W;   // first counter bit in the high port
  localparam int LO_LSB = HI_LSB - LO_FIELD_W;  // first counter bit in the low port
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic unusedWrTop;
  assign unusedWrTop = ^wrData[DATA_W-1:HI_FIELD_W];

  logic atMax;
  assign atMax = (accumCnt == CNT_MAX);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      accumCnt <= '0;
    end else if (strobes.load) begin
      accumCnt <= {wrData[HI_FIELD_W-1:0], {HI_LSB{1'b0}}};
    end else if (strobes.incr) begin
      accumCnt <= accumCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ovfFlag <= 1'b0;
    end else if (strobes.load) begin
      ovfFlag <= 1'b0;
    end else if (strobes.incr && atMax) begin
      ovfFlag <= 1'b1;
    end
  end

  // Captures the pre-increment value because it samples the current register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      snapField <= '0;
    end else if (strobes.snap) begin
      snapField <= accumCnt[LO_LSB +: LO_FIELD_W];
    end
  end

  always_comb begin
    rdData = '0;
    if (regSelHigh) begin
      rdData[DATA_W-1]       = ovfFlag;
      rdData[HI_FIELD_W-1:0] = accumCnt[CNT_W-1:HI_LSB];
    end else begin
      rdData[LO_LSB +: LO_FIELD_W] = snapField;
    end
  end

endmodule

// File: rtl/stall_accum_top.sv
module stall_accum_top
  import stall_accum_pkg::*;
#(
  parameter int CNT_W      = 12,
  parameter int HI_FIELD_W = 7,
  parameter int LO_FIELD_W = 4,
  parameter int DATA_W     = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              stallReq,
  input  logic              regSelHigh,
  input  logic              rdStrobe,
  input  logic              wrStrobe,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData
);

  ctrlStrobes_t          strobes;
  logic [CNT_W-1:0]      accumCnt;
  logic                  ovfFlag;
  logic [LO_FIELD_W-1:0] snapField;

  stall_accum_ctrl ctrl_i (
    .stallReq   (stallReq),
    .regSelHigh (regSelHigh),
    .rdStrobe   (rdStrobe),
    .wrStrobe   (wrStrobe),
    .strobes    (strobes)
  );

  stall_accum_dp #(
    .CNT_W      (CNT_W),
    .HI_FIELD_W (HI_FIELD_W),
    .LO_FIELD_W (LO_FIELD_W),
    .DATA_W     (DATA_W)
  ) dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .regSelHigh (regSelHigh),
    .wrData     (wrData),
    .rdData     (rdData),
    .accumCnt   (accumCnt),
    .ovfFlag    (ovfFlag),
    .snapField  (snapField)
  );

endmodule

// File: rtl/stall_accum_chk.sv
module stall_accum_chk #(
  parameter int CNT_W      = 12,
  parameter int HI_FIELD_W = 7,
  parameter int LO_FIELD_W = 4,
  parameter int DATA_W     = 8
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  stallReq,
  input logic                  regSelHigh,
  input logic                  rdStrobe,
  input logic                  wrStrobe,
  input logic [DATA_W-1:0]     wrData,
  input logic [DATA_W-1:0]     rdData,
  input logic [CNT_W-1:0]      accumCnt,
  input logic                  ovfFlag,
  input logic [LO_FIELD_W-1:0] snapField
);

  localparam int HI_LSB = CNT_W - HI_FIELD_W;
  localparam int LO_LSB = HI_LSB - LO_FIELD_W;

  logic hiWr;
  assign hiWr = wrStrobe & regSelHigh;

  // R1
  incr_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stallReq && !hiWr) |=> accumCnt == CNT_W'($past(accumCnt) + 1'b1));

  // R5
  hi_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    hiWr |=> accumCnt == {$past(wrData[HI_FIELD_W-1:0]), {HI_LSB{1'b0}}});

  // R8
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    hiWr |=> !ovfFlag);

  // R8
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ovfFlag && !hiWr) |=> ovfFlag);

  // R7
  wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stallReq && !hiWr && (&accumCnt)) |=> (ovfFlag && accumCnt == '0));

  // R4
  snap_take_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdStrobe && regSelHigh) |=> snapField == $past(accumCnt[LO_LSB +: LO_FIELD_W]));

  // R4
  snap_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(rdStrobe && regSelHigh) |=> $stable(snapField));

  // R9
  lo_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrStrobe && !regSelHigh && !stallReq) |=> ($stable(accumCnt) && $stable(ovfFlag)));

  // R3
  lo_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    !regSelHigh |-> (rdData[DATA_W-1:LO_LSB+LO_FIELD_W] == '0 && rdData[0] == 1'b0));

endmodule

bind stall_accum_top stall_accum_chk #(
  .CNT_W      (CNT_W),
  .HI_FIELD_W (HI_FIELD_W),
  .LO_FIELD_W (LO_FIELD_W),
  .DATA_W     (DATA_W)
) chk_i (
  .clk        (clk),
  .rstN       (rstN),
  .stallReq   (stallReq),
  .regSelHigh (regSelHigh),
  .rdStrobe   (rdStrobe),
  .wrStrobe   (wrStrobe),
  .wrData     (wrData),
  .rdData     (rdData),
  .accumCnt   (accumCnt),
  .ovfFlag    (ovfFlag),
  .snapField  (snapField)
);

// File: tb/stall_accum_tb.sv
module stall_accum_top_tb_top;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       stallReq = 1'b0;
  logic       regSelHigh = 1'b0;
  logic       rdStrobe = 1'b0;
  logic       wrStrobe = 1'b0;
  logic [7:0] wrData = '0;
  logic [7:0] rdData;

  int  nChecks = 0;
  int  nFails  = 0;
  bit  finished = 0;

  // Model state built from the requirements
  logic [11:0] mCnt  = '0;
  logic        mOvf  = 1'b0;
  logic [3:0]  mSnap = '0;

  always #2.5 clk = ~clk;

  stall_accum_top dut_i (
    .clk(clk), .rstN(rstN), .stallReq(stallReq), .regSelHigh(regSelHigh),
    .rdStrobe(rdStrobe), .wrStrobe(wrStrobe), .wrData(wrData), .rdData(rdData)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] expRead(input logic hi);
    return hi ? {mOvf, mCnt[11:5]} : {3'b000, mSnap, 1'b0};
  endfunction

  // One bus cycle, starting at a falling edge; rdData is checked before the edge
  task automatic busCycle(input string req, input logic stall, input logic hi,
                          input logic rd, input logic wr, input logic [7:0] wd,
                          input bit doCheck);
    logic [11:0] oldCnt;
    stallReq = stall; regSelHigh = hi; rdStrobe = rd; wrStrobe = wr; wrData = wd;
    #1;
    if (doCheck) check(req, rdData, expRead(hi));
    @(posedge clk);
    oldCnt = mCnt;
    if (wr && hi) begin
      mCnt = {wd[6:0], 5'b00000};
      mOvf = 1'b0;
    end else if (stall) begin
      if (mCnt == 12'hFFF) mOvf = 1'b1;
      mCnt = mCnt + 1'b1;
    end
    if (rd && hi) mSnap = oldCnt[4:1];
    @(negedge clk);
    stallReq = 0; rdStrobe = 0; wrStrobe = 0; wrData = '0;
  endtask

  task automatic stalls(input int n);
    for (int i = 0; i < n; i++) busCycle("R1", 1, 0, 0, 0, 8'h00, 0);
  endtask

  task automatic readHi(input string req);
    busCycle(req, 0, 1, 1, 0, 8'h00, 1);
  endtask

  task automatic readLo(input string req);
    busCycle(req, 0, 0, 1, 0, 8'h00, 1);
  endtask

  task automatic test_reset;
    readHi("R10 high");
    readLo("R10 low");
  endtask

  task automatic test_count;
    stalls(64);                     // 64 -> upper field 2
    readHi("R1/R2 count 64");
    stalls(37);                     // 101 -> upper 3, bits 4..1 = 2
    readHi("R1/R2 count 101");
    readLo("R3 low after 101");
    check("R3 low value 101", rdData, 8'h04);
  endtask

  task automatic test_snapshot;
    busCycle("R5 setup", 0, 1, 0, 1, 8'h12, 0);       // 0x240
    stalls(6);                                         // 0x246
    busCycle("R4 read with stall", 1, 1, 1, 0, 8'h00, 1); // snap 3, count 0x247
    readLo("R4 pre-increment snap");
    check("R4 low = 0x06", rdData, 8'h06);
    stalls(9);
    readLo("R4 snapshot held");
    check("R4 held = 0x06", rdData, 8'h06);
    readHi("R2 live high");
    readLo("R4 new snapshot");
  endtask

  task automatic test_write;
    busCycle("R5 write", 0, 1, 0, 1, 8'hD5, 0);
    readHi("R5 loaded, bit7 ignored");
    check("R8 flag not set by wrData7", rdData, 8'h55);
    readLo("R5 low cleared");
    check("R5 low zero", rdData, 8'h00);
  endtask

  task automatic test_collide;
    busCycle("R6 write+stall", 1, 1, 0, 1, 8'h21, 0);
    readHi("R6 write wins");
    readLo("R6 lower bits clear");
    check("R6 low zero", rdData, 8'h00);
  endtask

  task automatic test_wrap;
    busCycle("R7 setup", 0, 1, 0, 1, 8'h7F, 0);       // 0xFE0
    stalls(31);                                        // 0xFFF
    readHi("R7 at max");
    check("R7 max no flag", rdData, 8'h7F);
    readLo("R7 low at max");
    check("R7 low 0x1E", rdData, 8'h1E);
    stalls(1);
    readHi("R7 wrapped");
    check("R7 flag set count 0", rdData, 8'h80);
    stalls(40);
    readHi("R8 flag sticky");
    check("R8 sticky value", rdData, 8'h81);
    busCycle("R8 clear", 0, 1, 0, 1, 8'h80, 0);
    readHi("R8 cleared by write");
    check("R8 cleared value", rdData, 8'h00);
  endtask

  task automatic test_lowwrite;
    busCycle("R9 setup", 0, 1, 0, 1, 8'h0A, 0);
    stalls(10);
    readHi("R9 before");
    busCycle("R9 low write", 0, 0, 0, 1, 8'hFF, 0);
    readHi("R9 high unchanged");
    check("R9 high value", rdData, 8'h0A);
    readLo("R9 low unchanged");
    check("R9 low value", rdData, 8'h0A);
  endtask

  task automatic test_random;
    for (int i = 0; i < 3000; i++) begin
      logic s, h, r, w;
      s = ($urandom % 4) != 0;
      h = $urandom % 2;
      r = ($urandom % 3) == 0;
      w = ($urandom % 64) == 0;
      busCycle("R1-mix", s, h, r, w, 8'($urandom), 1);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    test_reset;
    test_count;
    test_snapshot;
    test_write;
    test_collide;
    test_wrap;
    test_lowwrite;
    test_random;
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

endmodule